// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block controls a successive-approximation converter that sits behind a four-channel sample-and-hold. When a start request arrives, it holds the sample-and-hold in its acquisition phase for a fixed number of clocks, so that every channel in the group is captured at the same instant. It then steps the converter through the enabled channels one at a time, with a fixed budget of clocks for each. Each 11-bit two's-complement result goes into a register for that channel. The host may read these registers in any order. At the end of the group the block can raise an interrupt.

A group always holds the V and W phase channels. Control bits add the U channel (three-phase current sensing) and one auxiliary input, chosen from four on an external expansion mux. That gives groups of two, three or four channels. A group can be started in three ways: by a host write to the start command address, by a rising edge on a conversion-start pin, or by a rising edge of the PWM period pulse. This lets the sampling line up with the PWM switching pattern. The analog converter is not part of this block: it is represented by a code input, which the block captures on the last clock of each channel's conversion.

Top module: `adc_group_seq`

## Requirements
- R1: After reset, all four result registers, the control register and the status register read 0, and `busy`, `irq`, `sample_hold` and `conv_active` are 0.
- R2: A write to address 1 (data ignored) while idle starts a group. `sample_hold` is then high for exactly ACQ_CYC clocks (20 by default), and `conv_active` rises only after `sample_hold` falls.
- R3: `busy` stays high for exactly ACQ_CYC + n*CONV_CYC clocks, where n is 2, 3 or 4 (100, 140 or 180 clocks by default). n = 2 + U enable + aux enable.
- R4: Channels are converted in the order V, W, then U if control bit 3 is set, then AUX if control bit 4 is set. `conv_chan` encodes V=0, W=1, U=2, AUX=3.
- R5: The host reads the result registers at read addresses 0 (V), 1 (W), 2 (U) and 3 (AUX). Each returns the 11-bit code that `conv_code` held on that channel's last conversion clock, sign-extended to 12 bits.
- R6: A result register changes only when its own channel finishes. A register read part-way through a group, before its channel is done, returns the previous group's value.
- R7: Control bits 1:0 (the control register is written at address 0 and read back at address 5) drive the `aux_sel` output.
- R8: With control bit 2 set, the end of a group sets status bit 0 (read address 4) and raises `irq`. With bit 2 clear, the flag stays 0 and `irq` stays low.
- R9: Reading the status address clears status bit 0, and `irq` falls in the next cycle.
- R10: A start request of any kind that arrives while a group is in progress is ignored. The group's length and channel order are unchanged.
- R11: With control bit 5 set, a rising edge on `conv_start_pin` starts a group. With bit 5 clear the pin has no effect. A pin held high does not start another group.
- R12: With control bit 6 set, a rising edge on `pwm_sync` starts a group. With bit 6 clear it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address (0 control, 1 start command) |
| wr_data | input | 12 | Host write data |
| rd_en | input | 1 | Host read strobe (a status read clears the flag) |
| rd_addr | input | 3 | Host read address (0-3 results, 4 status, 5 control) |
| rd_data | output | 12 | Read data for `rd_addr`, combinational |
| conv_start_pin | input | 1 | External conversion-start pin, rising edge |
| pwm_sync | input | 1 | PWM period pulse, rising edge |
| conv_code | input | 11 | Converter output code for the current channel |
| sample_hold | output | 1 | High while the sample-and-hold is acquiring |
| conv_active | output | 1 | High while a channel is being converted |
| conv_chan | output | 2 | Channel being converted (V=0, W=1, U=2, AUX=3) |
| aux_sel | output | 2 | Select for the auxiliary expansion mux |
| busy | output | 1 | A group is in progress |
| irq | output | 1 | End-of-group interrupt request |

## Verification
The bench runs groups of two, three and four channels. The `busy` length, the `sample_hold` length and the recorded `conv_chan` order separate the channel-count cases from one another. A distinct code per channel, including a negative one, shows that every result lands in its own register with the correct sign extension. A read in the middle of a group tells "updated at its own channel's end" apart from "updated at group end" or "updated at start". A second start issued in the middle of a group shows whether requests are blocked while busy. The pin and PWM triggers are each tried with their enable cleared, with it set, and held high, which separates edge from level detection and also tests the gating.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACQ  = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CH_V   = 2'd0,
        CH_W   = 2'd1,
        CH_U   = 2'd2,
        CH_AUX = 2'd3
    } chan_e;

    // control register bit positions
    localparam int unsigned CB_AUXSEL_LO = 0;
    localparam int unsigned CB_IRQ_EN    = 2;
    localparam int unsigned CB_U_EN      = 3;
    localparam int unsigned CB_AUX_EN    = 4;
    localparam int unsigned CB_PIN_EN    = 5;
    localparam int unsigned CB_PWM_EN    = 6;

    // host addresses
    localparam int unsigned WA_CTRL   = 0;
    localparam int unsigned WA_START  = 1;
    localparam int unsigned RA_STATUS = 4;
    localparam int unsigned RA_CTRL   = 5;

    // channel that follows cur in a group
    function automatic chan_e follow_chan(input chan_e cur, input logic u_en);
        chan_e nx;
        case (cur)
            CH_V:    nx = CH_W;
            CH_W:    nx = u_en ? CH_U : CH_AUX;
            CH_U:    nx = CH_AUX;
            default: nx = CH_AUX;
        endcase
        return nx;
    endfunction

    // true when cur is the final channel of the group
    function automatic logic is_last_chan(input chan_e cur, input logic u_en,
                                          input logic aux_en);
        logic last;
        case (cur)
            CH_V:    last = 1'b0;
            CH_W:    last = !u_en && !aux_en;
            CH_U:    last = !aux_en;
            default: last = 1'b1;
        endcase
        return last;
    endfunction

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_start,
    input  logic pin_start,
    input  logic pwm_sync,
    input  logic pin_en,
    input  logic pwm_en,
    output logic start_req
);

    typedef struct packed {
        logic pin;
        logic pwm;
    } trig_s;

    trig_s trig_d, trig_q;
    logic  pin_rise, pwm_rise;

    always_comb begin
        trig_d     = trig_q;
        trig_d.pin = pin_start;
        trig_d.pwm = pwm_sync;
        pin_rise   = pin_start && !trig_q.pin;
        pwm_rise   = pwm_sync && !trig_q.pwm;
        start_req  = sw_start || (pin_en && pin_rise) || (pwm_en && pwm_rise);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else begin
            trig_q <= trig_d;
        end
    end

    // R11: a pin held high never requests on its own
    a_r11_pin_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_start && !pwm_sync && pin_start && $past(pin_start)) |-> !start_req);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned ACQ_CYC  = 20,
    parameter int unsigned CONV_CYC = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       u_en,
    input  logic       aux_en,
    output logic       busy,
    output logic       sample_hold,
    output logic       conv_active,
    output logic [1:0] conv_chan,
    output logic       chan_done,
    output logic       group_done
);

    localparam int unsigned MAX_CYC = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        chan_e            ch;
        logic             u_en;
        logic             aux_en;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        chan_done  = 1'b0;
        group_done = 1'b0;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (start_req) begin
                    seq_d.st     = SEQ_ACQ;
                    seq_d.cnt    = '0;
                    seq_d.ch     = CH_V;
                    seq_d.u_en   = u_en;
                    seq_d.aux_en = aux_en;
                end
            end
            SEQ_ACQ: begin
                if (seq_q.cnt == ACQ_LAST) begin
                    seq_d.st  = SEQ_CONV;
                    seq_d.cnt = '0;
                    seq_d.ch  = CH_V;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_CONV: begin
                if (seq_q.cnt == CONV_LAST) begin
                    chan_done = 1'b1;
                    seq_d.cnt = '0;
                    if (is_last_chan(seq_q.ch, seq_q.u_en, seq_q.aux_en)) begin
                        seq_d.st   = SEQ_IDLE;
                        group_done = 1'b1;
                    end else begin
                        seq_d.ch = follow_chan(seq_q.ch, seq_q.u_en);
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0, ch: CH_V, u_en: 1'b0, aux_en: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy        = (seq_q.st != SEQ_IDLE);
    assign sample_hold = (seq_q.st == SEQ_ACQ);
    assign conv_active = (seq_q.st == SEQ_CONV);
    assign conv_chan   = seq_q.ch;

    // R2: conversion only ever follows the acquisition phase
    a_r2_acq_before_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_active) |-> $past(sample_hold));

    // R4: W is the channel that follows V
    a_r4_w_after_v: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && $past(conv_active) && $past(conv_chan) == CH_V
         && conv_chan != CH_V) |-> conv_chan == CH_W);

    // R4: U is never converted in a group whose U enable was clear
    a_r4_u_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && conv_chan == CH_U) |-> seq_q.u_en);

    // R10: a request while busy does not end the group early
    a_r10_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && !group_done) |=> busy);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CODE_W = 11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [$clog2(NCH)-1:0]         wsel,
    input  logic [CODE_W-1:0]              code,
    output logic [NCH-1:0][CODE_W-1:0]     res
);

    localparam int unsigned SEL_W = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] r;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NCH; i++) begin
            if (we && wsel == SEL_W'(i)) begin
                bank_d.r[i] = code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign res = bank_q.r;

    for (genvar g = 0; g < NCH; g++) begin : g_hold
        // R6: a register keeps its value unless its own channel finishes
        a_r6_hold_other: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && wsel == SEL_W'(g)) |=> $stable(bank_q.r[g]));
    end

endmodule

// File: rtl/adc_group_seq.sv
module adc_group_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned ACQ_CYC  = 20,
    parameter int unsigned CONV_CYC = 40,
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned CODE_W   = 11,
    parameter int unsigned ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              conv_start_pin,
    input  logic              pwm_sync,
    input  logic [CODE_W-1:0] conv_code,
    output logic              sample_hold,
    output logic              conv_active,
    output logic [1:0]        conv_chan,
    output logic [1:0]        aux_sel,
    output logic              busy,
    output logic              irq
);

    localparam int unsigned NCH   = 4;
    localparam int unsigned EXT_W = DATA_W - CODE_W;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              flag;
    } regs_s;

    regs_s regs_d, regs_q;

    logic                       sw_start, start_req, rd_clr;
    logic                       chan_done, group_done;
    logic [NCH-1:0][CODE_W-1:0] res;

    assign sw_start = wr_en && (wr_addr == ADDR_W'(WA_START));
    assign rd_clr   = rd_en && (rd_addr == ADDR_W'(RA_STATUS));

    adc_trig_detect u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_start  (sw_start),
        .pin_start (conv_start_pin),
        .pwm_sync  (pwm_sync),
        .pin_en    (regs_q.ctrl[CB_PIN_EN]),
        .pwm_en    (regs_q.ctrl[CB_PWM_EN]),
        .start_req (start_req)
    );

    adc_seq_ctrl #(
        .ACQ_CYC  (ACQ_CYC),
        .CONV_CYC (CONV_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .u_en        (regs_q.ctrl[CB_U_EN]),
        .aux_en      (regs_q.ctrl[CB_AUX_EN]),
        .busy        (busy),
        .sample_hold (sample_hold),
        .conv_active (conv_active),
        .conv_chan   (conv_chan),
        .chan_done   (chan_done),
        .group_done  (group_done)
    );

    adc_result_bank #(
        .NCH    (NCH),
        .CODE_W (CODE_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (chan_done),
        .wsel  (conv_chan),
        .code  (conv_code),
        .res   (res)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_addr == ADDR_W'(WA_CTRL)) begin
            regs_d.ctrl = wr_data;
        end
        if (rd_clr) begin
            regs_d.flag = 1'b0;
        end
        if (group_done && regs_q.ctrl[CB_IRQ_EN]) begin
            regs_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NCH)) begin
            rd_data = {{EXT_W{res[rd_addr[1:0]][CODE_W-1]}}, res[rd_addr[1:0]]};
        end else if (rd_addr == ADDR_W'(RA_STATUS)) begin
            rd_data = {{(DATA_W-2){1'b0}}, busy, regs_q.flag};
        end else if (rd_addr == ADDR_W'(RA_CTRL)) begin
            rd_data = regs_q.ctrl;
        end
    end

    assign aux_sel = regs_q.ctrl[CB_AUXSEL_LO +: 2];
    assign irq     = regs_q.flag && regs_q.ctrl[CB_IRQ_EN];

    // R8: an interrupt needs its enable
    a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> regs_q.ctrl[CB_IRQ_EN]);

    // R8: end of group with the enable set raises the request
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (group_done && regs_q.ctrl[CB_IRQ_EN] && !(wr_en && wr_addr == ADDR_W'(WA_CTRL)))
        |=> irq);

    // R9: a status read without a fresh group end drops the request
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !group_done) |=> !irq);

    // R10: a group only starts from idle
    a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req));

endmodule

// File: tb/adc_group_seq_test.sv
`timescale 1ns/1ps
module adc_group_seq_test;

    localparam int ACQ  = 20;
    localparam int CONV = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        pin = 1'b0;
    logic        pwm = 1'b0;
    logic [10:0] conv_code;
    logic        sample_hold, conv_active, busy, irq;
    logic [1:0]  conv_chan, aux_sel;
    logic [10:0] code_tab [4];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    assign conv_code = code_tab[conv_chan];

    adc_group_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_start_pin(pin), .pwm_sync(pwm), .conv_code(conv_code),
        .sample_hold(sample_hold), .conv_active(conv_active),
        .conv_chan(conv_chan), .aux_sel(aux_sel), .busy(busy), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 12'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input int a, output int d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'(a);
        #1 d = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic int sext(input logic [10:0] c);
        return int'({c[10], c});
    endfunction

    // counts busy / acquisition clocks and records channel order;
    // optionally pokes a software start at busy clock poke_at
    task automatic measure(input int poke_at, output int nb, output int nsh,
                           output int ord);
        int last = -1;
        nb = 0; nsh = 0; ord = 0;
        while (busy && nb < 1000) begin
            if (nb == poke_at) begin
                wr_en = 1'b1; wr_addr = 3'd1;
            end else begin
                wr_en = 1'b0;
            end
            nb++;
            if (sample_hold) nsh++;
            if (conv_active && int'(conv_chan) != last) begin
                last = int'(conv_chan);
                ord  = (ord << 2) | last;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        int d;
        check("R1 busy", busy, 0);
        check("R1 irq", irq, 0);
        check("R1 sample_hold", sample_hold, 0);
        check("R1 conv_active", conv_active, 0);
        for (int a = 0; a < 6; a++) begin
            host_rd(a, d);
            check($sformatf("R1 reg %0d", a), d, 0);
        end
    endtask

    task automatic t_two();
        int nb, nsh, ord, d;
        code_tab[0] = 11'h123; code_tab[1] = 11'h0F0;
        code_tab[2] = 11'h111; code_tab[3] = 11'h222;
        host_wr(0, 12'h000);
        host_wr(1, 12'hFFF);
        measure(-1, nb, nsh, ord);
        check("R3 two-channel busy", nb, ACQ + 2*CONV);
        check("R2 acquisition length", nsh, ACQ);
        check("R4 two-channel order", ord, 8'h01);
        host_rd(0, d); check("R5 V result", d, sext(11'h123));
        host_rd(1, d); check("R5 W result", d, sext(11'h0F0));
        host_rd(2, d); check("R5 U untouched", d, 0);
        host_rd(3, d); check("R5 AUX untouched", d, 0);
        check("R8 irq disabled", irq, 0);
        host_rd(4, d); check("R8 flag disabled", d, 0);
    endtask

    task automatic t_three();
        int nb, nsh, ord, d;
        code_tab[2] = 11'h2AB;
        host_wr(0, 12'h00C); // U enable + irq enable
        host_wr(1, 0);
        measure(-1, nb, nsh, ord);
        check("R3 three-channel busy", nb, ACQ + 3*CONV);
        check("R4 three-channel order", ord, 8'h06);
        check("R8 irq raised", irq, 1);
        host_rd(4, d); check("R8 status flag", d, 1);
        check("R9 irq cleared", irq, 0);
        host_rd(4, d); check("R9 status cleared", d, 0);
        host_rd(2, d); check("R5 U result", d, sext(11'h2AB));
    endtask

    task automatic t_four();
        int nb, nsh, ord, d;
        code_tab[0] = 11'h400; code_tab[1] = 11'h7FF;
        code_tab[2] = 11'h3FF; code_tab[3] = 11'h5A5;
        host_wr(0, 12'h01E); // aux_sel=2, irq, U, AUX
        check("R7 aux select", aux_sel, 2);
        host_rd(5, d); check("R7 control readback", d, 12'h01E);
        host_wr(1, 0);
        measure(-1, nb, nsh, ord);
        check("R3 four-channel busy", nb, ACQ + 4*CONV);
        check("R4 four-channel order", ord, 8'h1B);
        host_rd(0, d); check("R5 negative V", d, 12'hC00);
        host_rd(1, d); check("R5 minus one W", d, 12'hFFF);
        host_rd(2, d); check("R5 max U", d, 12'h3FF);
        host_rd(3, d); check("R5 AUX", d, sext(11'h5A5));
        host_rd(4, d);
    endtask

    task automatic t_early_read();
        int d, guard;
        code_tab[0] = 11'h055; code_tab[1] = 11'h066;
        code_tab[2] = 11'h077; code_tab[3] = 11'h088;
        host_wr(1, 0);
        guard = 0;
        while (!(conv_active && conv_chan == 2'd1) && guard < 500) begin
            @(negedge clk); guard++;
        end
        host_rd(2, d); check("R6 U still previous", d, 12'h3FF);
        host_rd(3, d); check("R6 AUX still previous", d, sext(11'h5A5));
        host_rd(0, d); check("R6 V already new", d, 12'h055);
        guard = 0;
        while (busy && guard < 500) begin @(negedge clk); guard++; end
        host_rd(2, d); check("R6 U new at end", d, 12'h077);
        host_rd(4, d);
    endtask

    task automatic t_restart();
        int nb, nsh, ord;
        host_wr(0, 12'h000);
        host_wr(1, 0);
        measure(30, nb, nsh, ord);
        check("R10 busy unchanged by restart", nb, ACQ + 2*CONV);
        check("R10 order unchanged", ord, 8'h01);
        repeat (3) @(negedge clk);
        check("R10 no queued start", busy, 0);
    endtask

    task automatic t_pin();
        int nb, nsh, ord;
        host_wr(0, 12'h000);
        @(negedge clk); pin = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 pin disabled", busy, 0);
        pin = 1'b0;
        host_wr(0, 12'h020);
        @(negedge clk); pin = 1'b1;
        @(negedge clk);
        measure(-1, nb, nsh, ord);
        check("R11 pin start", nb, ACQ + 2*CONV);
        repeat (5) @(negedge clk);
        check("R11 held pin no retrigger", busy, 0);
        pin = 1'b0;
    endtask

    task automatic t_pwm();
        int nb, nsh, ord;
        host_wr(0, 12'h000);
        @(negedge clk); pwm = 1'b1;
        @(negedge clk); pwm = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 pwm disabled", busy, 0);
        host_wr(0, 12'h048); // pwm enable + U enable
        @(negedge clk); pwm = 1'b1;
        @(negedge clk); pwm = 1'b0;
        measure(-1, nb, nsh, ord);
        check("R12 pwm start", nb, ACQ + 3*CONV);
    endtask

    initial begin
        code_tab[0] = '0; code_tab[1] = '0; code_tab[2] = '0; code_tab[3] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two();
        t_three();
        t_four();
        t_early_read();
        t_restart();
        t_pin();
        t_pwm();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule